// File: doc/BRIEF.md
# Clock-Gated Serial Slave Port

This block is the slave end of a synchronous serial link. The far end supplies the transfer clock. A two-wire hold handshake lets either side pause the link. The block samples the external clock, the hold lines and the serial input into its own system clock domain. It acts on the rising edges of the transfer clock, but only while the hold handshake is released. Each accepted edge shifts one bit in, most significant bit first, and moves the next transmit bit onto the serial output. After eight accepted edges the received byte is presented on a parallel port.

The block drives a hold request back to the far end. In per-byte mode the request is raised whenever the transmit buffer has not been reloaded or the received byte has not been read. In whole-frame mode the request is raised only before a frame starts and after it ends, and stays low between the bytes of the frame. The hold input and the hold output are each offered in a true form and an inverted form. The serial output has an enable, which can follow the hold input so that the output goes high-impedance while the link is paused.

Top module: `ssb_slave`

## Requirements
- R1: While `init_en` is 0, `hold_out` is 0 and `hold_out_n` is 1, no transfer-clock edge is accepted, and any partly shifted byte is discarded, so the next byte starts again at bit 7.
- R2: Each accepted rising edge of `sclk_in` shifts `sdi` in, most significant bit first. On the eighth accepted edge, `byte_done` pulses for one cycle, and on the following cycle `rx_data` holds the byte and `rx_valid` is 1.
- R3: A byte loaded with `tx_load` while no byte is in progress drives its bit 7 on `sdo` before the first accepted edge. Each accepted edge moves `sdo` to the next lower bit.
- R4: While the hold input is asserted (`hold_in` = 1 or `hold_in_n` = 0), rising edges of `sclk_in` are ignored: no bit is shifted, the bit count is frozen and `sdo` does not change.
- R5: With `hiz_mode` = 1, `sdo_oe` is 1 only while the hold input is released and 0 while it is asserted. With `hiz_mode` = 0, `sdo_oe` is always 1.
- R6: With `busy_whole` = 0 and `init_en` = 1, `hold_out` is 1 whenever the transmit buffer has not been loaded since the last byte or `rx_valid` is 1. It drops once the buffer is loaded and the received byte has been read with `rx_read`.
- R7: With `busy_whole` = 1, a frame is `frame_len_m1`+1 bytes long. `hold_out` stays 0 between the bytes of a frame and obeys the R6 rule only before the first byte and after the last byte.
- R8: `hold_out_n` is always the complement of `hold_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| init_en | input | 1 | 1 enables the port; 0 holds it idle and clears progress |
| hiz_mode | input | 1 | 1 lets the hold input gate the serial output enable |
| busy_whole | input | 1 | 0: hold request per byte; 1: per frame |
| frame_len_m1 | input | FW (4) | Frame length in bytes minus one (whole-frame mode) |
| sclk_in | input | 1 | External transfer clock, idle high |
| hold_in | input | 1 | Hold request from the far end, active high |
| hold_in_n | input | 1 | Hold request from the far end, active low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |
| hold_out | output | 1 | Hold request to the far end, active high |
| hold_out_n | output | 1 | Hold request to the far end, active low |
| tx_data | input | DW (8) | Byte to transmit |
| tx_load | input | 1 | Load pulse for `tx_data` |
| rx_data | output | DW (8) | Last received byte |
| rx_valid | output | 1 | Received byte not yet read |
| rx_read | input | 1 | Read acknowledge pulse |
| byte_done | output | 1 | One-cycle pulse on the eighth accepted edge |

## Verification
The assertions check on every cycle that the bit count stays frozen while the synchronized hold input is asserted, and that each accepted edge short of the last advances it by one. They also check that a completed byte always leaves `rx_valid` set, that the hold request is idle while the port is disabled, and that loading the buffer with nothing unread releases the per-byte request. Only the bench scenarios can show the end-to-end effects: bit ordering on both serial lines, that clock pulses issued during a hold leave the received byte untouched under both input polarities, that a partial byte is discarded by de-initialization, and how the two hold-output modes differ across a two-byte frame.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

    typedef enum logic {
        HOLD_PER_BYTE = 1'b0,
        HOLD_WHOLE    = 1'b1
    } hold_mode_e;

    // one sampled view of the external lines, aligned in time
    typedef struct packed {
        logic rise;   // rising edge of the transfer clock
        logic hold;   // hold input asserted (either polarity)
        logic sdi;    // serial input at the same sample
    } line_evt_t;

    function automatic logic hold_asserted(input logic act_hi, input logic act_lo_n);
        return act_hi | ~act_lo_n;
    endfunction

endpackage

// File: rtl/ssb_sync.sv
module ssb_sync
    import ssb_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk_in,
    input  logic      hold_in,
    input  logic      hold_in_n,
    input  logic      sdi,
    output line_evt_t evt
);
    logic [STAGES:0]   sclk_q;
    logic [STAGES-1:0] hold_q;
    logic [STAGES-1:0] sdi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= '1;
            hold_q <= '1;
            sdi_q  <= '0;
        end else begin
            sclk_q <= {sclk_q[STAGES-1:0], sclk_in};
            hold_q <= {hold_q[STAGES-2:0], hold_asserted(hold_in, hold_in_n)};
            sdi_q  <= {sdi_q[STAGES-2:0], sdi};
        end
    end

    always_comb begin
        evt.rise = sclk_q[STAGES-1] & ~sclk_q[STAGES];
        evt.hold = hold_q[STAGES-1];
        evt.sdi  = sdi_q[STAGES-1];
    end
endmodule

// File: rtl/ssb_shift.sv
module ssb_shift
    import ssb_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init_en,
    input  line_evt_t     evt,
    input  logic          tx_load,
    input  logic [DW-1:0] tx_data,
    output logic          sdo_bit,
    output logic [DW-1:0] rx_data,
    output logic          byte_done,
    output logic          tx_taken
);
    localparam int unsigned CW = $clog2(DW);

    logic [DW-1:0] shreg;
    logic [CW-1:0] bit_cnt;
    logic          accept;
    logic          last;

    assign accept    = evt.rise & ~evt.hold & init_en;
    assign last      = (bit_cnt == CW'(DW - 1));
    assign byte_done = accept & last;
    assign tx_taken  = tx_load & init_en & (bit_cnt == '0);
    assign sdo_bit   = shreg[DW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
            rx_data <= '0;
        end else if (!init_en) begin
            bit_cnt <= '0;
        end else if (accept) begin
            shreg   <= {shreg[DW-2:0], evt.sdi};
            bit_cnt <= last ? '0 : bit_cnt + 1'b1;
            if (last) rx_data <= {shreg[DW-2:0], evt.sdi};
        end else if (tx_taken) begin
            shreg <= tx_data;
        end
    end

    a_r4_count_frozen: assert property (@(posedge clk) disable iff (rst)
        (init_en && evt.hold) |=> $stable(bit_cnt));

    a_r3_count_steps: assert property (@(posedge clk) disable iff (rst)
        (accept && !last) |=> (bit_cnt == $past(bit_cnt) + 1'b1));
endmodule

// File: rtl/ssb_hshake.sv
module ssb_hshake
    import ssb_pkg::*;
#(
    parameter int unsigned FW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init_en,
    input  logic          byte_done,
    input  logic          tx_taken,
    input  logic          rx_read,
    input  hold_mode_e    mode,
    input  logic [FW-1:0] frame_len_m1,
    output logic          hold_act,
    output logic          rx_valid
);
    logic          tx_full;
    logic          rx_unread;
    logic [FW-1:0] frame_cnt;
    logic          ready;
    logic          at_frame_edge;

    always_ff @(posedge clk) begin
        if (rst || !init_en) begin
            tx_full   <= 1'b0;
            rx_unread <= 1'b0;
            frame_cnt <= '0;
        end else begin
            if (byte_done)     tx_full <= 1'b0;
            else if (tx_taken) tx_full <= 1'b1;

            if (byte_done)    rx_unread <= 1'b1;
            else if (rx_read) rx_unread <= 1'b0;

            if (byte_done)
                frame_cnt <= (frame_cnt >= frame_len_m1) ? '0 : frame_cnt + 1'b1;
        end
    end

    assign ready         = tx_full & ~rx_unread;
    assign at_frame_edge = (mode == HOLD_PER_BYTE) || (frame_cnt == '0);
    assign hold_act      = init_en & ~ready & at_frame_edge;
    assign rx_valid      = rx_unread;

    a_r2_byte_flags: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> rx_valid);

    a_r6_load_releases: assert property (@(posedge clk) disable iff (rst)
        (init_en && $rose(tx_full) && !rx_unread && mode == HOLD_PER_BYTE) |-> !hold_act);
endmodule

// File: rtl/ssb_slave.sv
module ssb_slave
    import ssb_pkg::*;
#(
    parameter int unsigned DW     = 8,
    parameter int unsigned FW     = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init_en,
    input  logic          hiz_mode,
    input  logic          busy_whole,
    input  logic [FW-1:0] frame_len_m1,
    input  logic          sclk_in,
    input  logic          hold_in,
    input  logic          hold_in_n,
    input  logic          sdi,
    output logic          sdo,
    output logic          sdo_oe,
    output logic          hold_out,
    output logic          hold_out_n,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_load,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    input  logic          rx_read,
    output logic          byte_done
);
    line_evt_t evt;
    logic      tx_taken;
    logic      hold_act;

    ssb_sync #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst(rst), .sclk_in(sclk_in), .hold_in(hold_in),
        .hold_in_n(hold_in_n), .sdi(sdi), .evt(evt)
    );

    ssb_shift #(.DW(DW)) u_shift (
        .clk(clk), .rst(rst), .init_en(init_en), .evt(evt),
        .tx_load(tx_load), .tx_data(tx_data), .sdo_bit(sdo),
        .rx_data(rx_data), .byte_done(byte_done), .tx_taken(tx_taken)
    );

    ssb_hshake #(.FW(FW)) u_hs (
        .clk(clk), .rst(rst), .init_en(init_en), .byte_done(byte_done),
        .tx_taken(tx_taken), .rx_read(rx_read), .mode(hold_mode_e'(busy_whole)),
        .frame_len_m1(frame_len_m1), .hold_act(hold_act), .rx_valid(rx_valid)
    );

    assign hold_out   = hold_act;
    assign hold_out_n = ~hold_act;
    assign sdo_oe     = ~hiz_mode | ~evt.hold;

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !init_en |-> (!hold_out && hold_out_n));

    a_r1_no_done_idle: assert property (@(posedge clk) disable iff (rst)
        !init_en |-> !byte_done);
endmodule

// File: tb/ssb_slave_test.sv
module ssb_slave_test;
    localparam int DW = 8;
    localparam int FW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          init_en, hiz_mode, busy_whole;
    logic [FW-1:0] frame_len_m1;
    logic          sclk_in, hold_in, hold_in_n, sdi;
    logic          sdo, sdo_oe, hold_out, hold_out_n;
    logic [DW-1:0] tx_data;
    logic          tx_load;
    logic [DW-1:0] rx_data;
    logic          rx_valid, rx_read, byte_done;

    int n_chk  = 0;
    int n_fail = 0;
    int done_cnt = 0;
    logic [DW-1:0] exp_q[$];

    always #10 clk = ~clk;

    ssb_slave uut (
        .clk(clk), .rst(rst), .init_en(init_en), .hiz_mode(hiz_mode),
        .busy_whole(busy_whole), .frame_len_m1(frame_len_m1),
        .sclk_in(sclk_in), .hold_in(hold_in), .hold_in_n(hold_in_n), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .hold_out(hold_out), .hold_out_n(hold_out_n),
        .tx_data(tx_data), .tx_load(tx_load), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_read(rx_read), .byte_done(byte_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops the expected received byte on each completed byte (R2)
    always @(negedge clk) begin
        if (byte_done) begin
            done_cnt++;
            @(negedge clk);
            if (exp_q.size() == 0) begin
                check("R2 unexpected byte", 32'(rx_data), 32'hDEAD);
            end else begin
                check("R2 rx_data", 32'(rx_data), 32'(exp_q.pop_front()));
                check("R2 rx_valid", 32'(rx_valid), 32'd1);
            end
        end
    end

    // one transfer-clock pulse, sdo sampled while the clock is low
    task automatic clk_pulse(input logic din, output logic dout);
        sclk_in = 1'b0;
        sdi     = din;
        wait_clk(6);
        dout    = sdo;
        sclk_in = 1'b1;
        wait_clk(6);
    endtask

    task automatic set_hold(input logic on, input logic use_n);
        if (use_n) hold_in_n = ~on; else hold_in = on;
        wait_clk(4);
    endtask

    task automatic load(input logic [DW-1:0] d);
        tx_data = d;
        tx_load = 1'b1;
        wait_clk(1);
        tx_load = 1'b0;
        wait_clk(2);
    endtask

    task automatic read_rx();
        rx_read = 1'b1;
        wait_clk(1);
        rx_read = 1'b0;
        wait_clk(2);
    endtask

    // driver: expects rx_in to be received and tx_exp to appear on sdo;
    // gap_at >= 0 inserts six held pulses before that bit (R4)
    task automatic xfer_byte(input logic [DW-1:0] tx_exp, input logic [DW-1:0] rx_in,
                             input int gap_at, input logic use_n);
        logic [DW-1:0] got;
        logic          b;
        logic          sdo_before;
        int            done_before;
        exp_q.push_back(rx_in);
        for (int i = 0; i < DW; i++) begin
            if (i == gap_at) begin
                set_hold(1'b1, use_n);
                sdo_before  = sdo;
                done_before = done_cnt;
                for (int k = 0; k < 6; k++) clk_pulse(~rx_in[DW-1-i], b);
                check("R4 no byte while held", 32'(done_cnt), 32'(done_before));
                check("R4 sdo frozen while held", 32'(sdo), 32'(sdo_before));
                set_hold(1'b0, use_n);
            end
            clk_pulse(rx_in[DW-1-i], b);
            got[DW-1-i] = b;
        end
        check("R3 sdo bit order", 32'(got), 32'(tx_exp));
        wait_clk(2);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic dummy;
        rst = 1'b1; init_en = 1'b0; hiz_mode = 1'b0; busy_whole = 1'b0;
        frame_len_m1 = '0; sclk_in = 1'b1; hold_in = 1'b0; hold_in_n = 1'b1;
        sdi = 1'b0; tx_data = '0; tx_load = 1'b0; rx_read = 1'b0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);

        // R1 / R8 idle state
        check("R1 hold_out idle", 32'(hold_out), 32'd0);
        check("R8 hold_out_n idle", 32'(hold_out_n), 32'd1);
        check("R2 rx_valid reset", 32'(rx_valid), 32'd0);
        check("R5 sdo_oe reset", 32'(sdo_oe), 32'd1);
        for (int k = 0; k < 9; k++) clk_pulse(1'b1, dummy);
        check("R1 edges ignored when idle", 32'(done_cnt), 32'd0);

        // R6 per-byte handshake
        init_en = 1'b1;
        wait_clk(2);
        check("R6 empty buffer holds", 32'(hold_out), 32'd1);
        check("R8 complement", 32'(hold_out_n), 32'd0);
        load(8'h3C);
        check("R6 loaded releases", 32'(hold_out), 32'd0);
        xfer_byte(8'h3C, 8'hA5, -1, 1'b0);
        check("R6 after byte holds", 32'(hold_out), 32'd1);
        read_rx();
        check("R6 read but empty holds", 32'(hold_out), 32'd1);
        load(8'hC3);
        check("R6 reload releases", 32'(hold_out), 32'd0);

        // R4 gating, both input polarities
        xfer_byte(8'hC3, 8'h5A, 3, 1'b0);
        read_rx();
        load(8'h81);
        xfer_byte(8'h81, 8'h7E, 5, 1'b1);
        load(8'h66);
        check("R6 unread byte holds", 32'(hold_out), 32'd1);
        read_rx();
        check("R6 read releases", 32'(hold_out), 32'd0);
        xfer_byte(8'h66, 8'h19, -1, 1'b0);
        read_rx();

        // R5 output enable
        hiz_mode = 1'b1;
        set_hold(1'b1, 1'b0);
        check("R5 hiz while held", 32'(sdo_oe), 32'd0);
        set_hold(1'b0, 1'b0);
        check("R5 driven when released", 32'(sdo_oe), 32'd1);
        set_hold(1'b1, 1'b1);
        check("R5 hiz while held (inverted)", 32'(sdo_oe), 32'd0);
        hiz_mode = 1'b0;
        wait_clk(1);
        check("R5 always driven", 32'(sdo_oe), 32'd1);
        set_hold(1'b0, 1'b1);

        // R1 de-initialization discards a partial byte
        load(8'hF0);
        for (int k = 0; k < 3; k++) clk_pulse(1'b1, dummy);
        init_en = 1'b0;
        wait_clk(2);
        check("R1 hold idle after clear", 32'(hold_out), 32'd0);
        init_en = 1'b1;
        wait_clk(1);
        load(8'h0F);
        xfer_byte(8'h0F, 8'h96, -1, 1'b0);
        read_rx();

        // R7 whole-frame mode, two bytes
        busy_whole = 1'b1;
        frame_len_m1 = 4'd1;
        wait_clk(2);
        check("R7 holds before frame", 32'(hold_out), 32'd1);
        load(8'h11);
        check("R7 released at start", 32'(hold_out), 32'd0);
        xfer_byte(8'h11, 8'h22, -1, 1'b0);
        check("R7 released between bytes", 32'(hold_out), 32'd0);
        read_rx();
        load(8'h44);
        xfer_byte(8'h44, 8'h88, -1, 1'b0);
        check("R7 holds after frame", 32'(hold_out), 32'd1);
        read_rx();

        check("R2 all bytes seen", 32'(exp_q.size()), 32'd0);
        report();
    end
endmodule